// File: doc/BRIEF.md
# DDR Clock-Enable Power-State Tracker

This block follows a DDR SDRAM device through its low-power states by watching what the controller drives onto the device pins. At every rising clock edge it looks at two things together: the clock-enable level registered at the previous edge and at the current edge, and the decoded command registered at the current edge. From these it decides whether the device stays where it is, enters self refresh or one of the two power-down flavours, or returns to normal operation. It also raises a one-cycle error pulse when the controller produces a sequence the device does not allow.

After an exit from self refresh, the tracker opens two windows that both start on the exit edge. The first is a short settling window during which only DESELECT or NOP may be issued. The second is a longer lock window during which reads are held off so the device's delay-locked loop can re-lock. A `read_ok` output tells the controller when a READ may be issued again. Idle or active bank state is followed from ACTIVE and PRECHARGE commands. A bank-open hint from the controller says whether any bank is still open once a PRECHARGE has been issued.

The tracker is passive. It sits beside a memory controller as a protocol monitor or as the source of power-state status for that controller.

Top module: `cke_pwr_tracker`

## Requirements
- R1: After synchronous reset the state output is all-banks-idle, `read_ok` is 1 and `err` is 0. State codes are: idle 0, banks active 1, precharge power-down 2, active power-down 3, self refresh 4.
- R2: In self refresh, if clock enable was low at the previous edge and is low at the current edge, the state stays self refresh whatever the command.
- R3: In self refresh, if clock enable rises from low to high while the command is DESELECT (code 0) or NOP (code 1), the state becomes idle.
- R4: In either power-down state, low-low clock enable keeps the state. A low-to-high rise with DESELECT or NOP leaves power-down: precharge power-down returns to idle and active power-down returns to banks active.
- R5: From idle with clock enable falling high to low, DESELECT or NOP enters precharge power-down and AUTO REFRESH (code 2) enters self refresh.
- R6: From banks active with clock enable falling high to low, DESELECT or NOP enters active power-down.
- R7: With clock enable high at both edges, ACTIVE (code 3) moves idle to banks active. PRECHARGE (code 4) moves banks active to idle only when `bank_open` is low; when it is high the state stays banks active.
- R8: For the `SRX_CYC` edges that follow a self-refresh exit edge, any command other than DESELECT or NOP is an error.
- R9: `read_ok` is low from the self-refresh exit edge until `RD_LOCK` edges have passed since that exit. A READ (code 5) issued while `read_ok` is low is an error.
- R10: Every state, clock-enable pair and command combination not covered by R2 to R9 is an error. An error raises `err` for exactly the cycle after the offending edge, and the state is left unchanged at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level as registered by the device at this edge |
| cmd | input | 3 | Decoded command at this edge (0 DESELECT, 1 NOP, 2 AUTO REFRESH, 3 ACTIVE, 4 PRECHARGE, 5 READ, 6 WRITE, 7 MODE) |
| bank_open | input | 1 | High when at least one bank remains open |
| state | output | 3 | Registered power state code |
| read_ok | output | 1 | High when a READ may be issued |
| err | output | 1 | One-cycle pulse marking an illegal sequence |

## Verification
The hardest case to reach is where the self-refresh exit window and the read lock window overlap, and both interact with a later fall of clock enable. To get there the controller must first enter self refresh through AUTO REFRESH with a falling clock enable, hold it low, and then exit with a NOP. Only after that can ACTIVE, AUTO REFRESH or READ be placed inside each window and just past its edge. The stimulus walks this path in a directed way several times, placing commands one edge before and exactly at each window boundary. A long biased random phase then mixes entries and exits while a behavioural model, which counts edges since the last exit, is compared with the outputs on every clock.

// File: rtl/ckepd_pkg.sv
package ckepd_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_READ  = 3'd5,
    CMD_WRITE = 3'd6,
    CMD_MODE  = 3'd7
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_ACTV = 3'd1,
    PS_PPD  = 3'd2,
    PS_APD  = 3'd3,
    PS_SREF = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/ckepd_timer.sv
// Down-counter window: loads LOAD on start, then counts to zero, one step per edge.
module ckepd_timer #(
  parameter int LOAD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int W = $clog2(LOAD + 2);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= W'(LOAD);
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ckepd_decide.sv
// Next-state and legality decision for one clock edge.
module ckepd_decide
  import ckepd_pkg::*;
(
  input  pwr_state_e state,
  input  logic       cke_prev,
  input  logic       cke_now,
  input  ddr_cmd_e   cmd,
  input  logic       bank_open,
  input  logic       win_busy,
  input  logic       lock_busy,
  output pwr_state_e nstate,
  output logic       bad,
  output logic       sr_exit
);
  logic quiet;
  assign quiet = (cmd == CMD_DESEL) || (cmd == CMD_NOP);

  always_comb begin
    nstate  = state;
    bad     = 1'b0;
    sr_exit = 1'b0;
    case (state)
      PS_SREF: begin
        if (!cke_prev && !cke_now) begin
          nstate = state;
        end else if (!cke_prev && cke_now && quiet) begin
          nstate  = PS_IDLE;
          sr_exit = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      PS_PPD, PS_APD: begin
        if (!cke_prev && !cke_now) begin
          nstate = state;
        end else if (!cke_prev && cke_now && quiet) begin
          nstate = (state == PS_APD) ? PS_ACTV : PS_IDLE;
        end else begin
          bad = 1'b1;
        end
      end
      PS_IDLE, PS_ACTV: begin
        if (!cke_prev) begin
          bad = 1'b1;
        end else if (win_busy && !quiet) begin
          bad = 1'b1;
        end else if (!cke_now) begin
          if (quiet)
            nstate = (state == PS_ACTV) ? PS_APD : PS_PPD;
          else if (cmd == CMD_AREF && state == PS_IDLE)
            nstate = PS_SREF;
          else
            bad = 1'b1;
        end else if (cmd == CMD_READ && lock_busy) begin
          bad = 1'b1;
        end else if (cmd == CMD_ACT) begin
          nstate = PS_ACTV;
        end else if (cmd == CMD_PRE && state == PS_ACTV && !bank_open) begin
          nstate = PS_IDLE;
        end
      end
      default: begin
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
  import ckepd_pkg::*;
#(
  parameter int SRX_CYC = 10,
  parameter int RD_LOCK = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       bank_open,
  output logic [2:0] state,
  output logic       read_ok,
  output logic       err
);
  localparam int LOCK_LOAD = (RD_LOCK > 1) ? RD_LOCK - 1 : 0;

  pwr_state_e st_q, st_n;
  logic       cke_q;
  logic       bad, sr_exit;
  logic       win_busy, lock_busy;
  ddr_cmd_e   cmd_e;

  assign cmd_e = ddr_cmd_e'(cmd);

  ckepd_decide u_decide (
    .state     (st_q),
    .cke_prev  (cke_q),
    .cke_now   (cke),
    .cmd       (cmd_e),
    .bank_open (bank_open),
    .win_busy  (win_busy),
    .lock_busy (lock_busy),
    .nstate    (st_n),
    .bad       (bad),
    .sr_exit   (sr_exit)
  );

  ckepd_timer #(.LOAD(SRX_CYC)) u_exit_win (
    .clk   (clk),
    .rst   (rst),
    .start (sr_exit),
    .busy  (win_busy)
  );

  ckepd_timer #(.LOAD(LOCK_LOAD)) u_read_lock (
    .clk   (clk),
    .rst   (rst),
    .start (sr_exit),
    .busy  (lock_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_IDLE;
      cke_q <= 1'b1;
      err   <= 1'b0;
    end else begin
      st_q  <= st_n;
      cke_q <= cke;
      err   <= bad;
    end
  end

  assign state   = st_q;
  assign read_ok = !lock_busy;
endmodule

// File: rtl/ckepd_chk.sv
module ckepd_chk
  import ckepd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       bank_open,
  input logic [2:0] state,
  input logic       read_ok,
  input logic       err
);
  logic quiet;
  assign quiet = (cmd == CMD_DESEL) || (cmd == CMD_NOP);

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (state == PS_IDLE && read_ok && !err));

  p_sref_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SREF && !$past(cke) && !cke) |=> state == PS_SREF);

  p_sref_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SREF && !$past(cke) && cke && quiet) |=> state == PS_IDLE);

  p_apd_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (state == PS_APD && !$past(cke) && cke && quiet) |=> state == PS_ACTV);

  p_ppd_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state == PS_IDLE && $past(cke) && !cke && quiet && !err) |=> (state == PS_PPD || err));

  p_lock_after_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == PS_SREF && state == PS_IDLE) |-> !read_ok);

  p_err_holds_state_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(rst)) |-> state == $past(state));
endmodule

bind cke_pwr_tracker ckepd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .cmd       (cmd),
  .bank_open (bank_open),
  .state     (state),
  .read_ok   (read_ok),
  .err       (err)
);

// File: tb/tb_cke_pwr_tracker.sv
`timescale 1ns/1ps
module tb_cke_pwr_tracker;
  localparam int SRX = 10;
  localparam int RDL = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [2:0] cmd = 3'd1;
  logic       bank_open = 1'b0;
  logic [2:0] state;
  logic       read_ok;
  logic       err;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cke_pwr_tracker #(.SRX_CYC(SRX), .RD_LOCK(RDL)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank_open(bank_open),
    .state(state), .read_ok(read_ok), .err(err)
  );

  // behavioural reference: counts edges since the last self-refresh exit
  int    m_st  = 0;
  int    m_ckq = 1;
  int    since = 1000000;
  int    m_err = 0;
  int    m_rok = 1;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_ckq = 1; since = 1000000; m_err = 0; m_rok = 1; m_tag = "R1";
    end else begin
      int k, c, e, ex, nxt, q;
      k = (since >= 1000000) ? since : since + 1;
      c = int'(cmd);
      q = (c == 0 || c == 1) ? 1 : 0;
      e = 0; ex = 0; nxt = m_st;
      if (m_st == 4) begin
        if (m_ckq == 0 && cke == 0)              m_tag = "R2";
        else if (m_ckq == 0 && cke && q == 1) begin nxt = 0; ex = 1; m_tag = "R3"; end
        else begin e = 1; m_tag = "R10"; end
      end else if (m_st == 2 || m_st == 3) begin
        if (m_ckq == 0 && cke == 0)              m_tag = "R4";
        else if (m_ckq == 0 && cke && q == 1) begin nxt = (m_st == 3) ? 1 : 0; m_tag = "R4"; end
        else begin e = 1; m_tag = "R10"; end
      end else begin
        if (m_ckq == 0) begin e = 1; m_tag = "R10"; end
        else if (k <= SRX && q == 0) begin e = 1; m_tag = "R8"; end
        else if (cke == 0) begin
          if (q == 1) begin nxt = (m_st == 1) ? 3 : 2; m_tag = (m_st == 1) ? "R6" : "R5"; end
          else if (c == 2 && m_st == 0) begin nxt = 4; m_tag = "R5"; end
          else begin e = 1; m_tag = "R10"; end
        end
        else if (c == 5 && k < RDL) begin e = 1; m_tag = "R9"; end
        else if (c == 3) begin nxt = 1; m_tag = "R7"; end
        else if (c == 4 && m_st == 1 && !bank_open) begin nxt = 0; m_tag = "R7"; end
        else m_tag = "R7";
      end
      m_st  = nxt;
      m_err = e;
      m_ckq = cke ? 1 : 0;
      since = ex ? 0 : k;
      m_rok = (since + 1 >= RDL) ? 1 : 0;
    end
  end

  task automatic compare();
    n_run++;
    if (int'(state) != m_st || int'(read_ok) != m_rok || int'(err) != m_err) begin
      n_bad++;
      $display("FAIL %s: state/read_ok/err = %0d/%0d/%0d, expected %0d/%0d/%0d",
               m_tag, state, read_ok, err, m_st, m_rok, m_err);
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c_ke, input int c_md, input logic bo);
    @(negedge clk);
    cke = c_ke; cmd = 3'(c_md); bank_open = bo;
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 state", int'(state), 0);
    chk("R1 read_ok", int'(read_ok), 1);
    chk("R1 err", int'(err), 0);

    // R5 precharge power-down, R4 hold and exit
    step(1, 1, 0); step(0, 0, 0); chk("R5 ppd", int'(state), 2);
    step(0, 6, 0); step(0, 3, 0); chk("R4 hold", int'(state), 2);
    step(1, 1, 0); chk("R4 exit idle", int'(state), 0);
    // R7 bank tracking, R6 active power-down
    step(1, 3, 0); chk("R7 act", int'(state), 1);
    step(0, 1, 0); chk("R6 apd", int'(state), 3);
    step(1, 0, 0); chk("R4 exit actv", int'(state), 1);
    step(1, 4, 1); chk("R7 pre open", int'(state), 1);
    step(1, 4, 0); chk("R7 pre closed", int'(state), 0);
    // R10 falling CKE with READ
    step(1, 1, 0); step(0, 5, 0); chk("R10 err", int'(err), 1);
    chk("R10 state kept", int'(state), 0);
    step(1, 1, 0); step(1, 1, 0);
    // R5 self refresh entry, R2 hold, R3 exit with bad command then good
    step(0, 2, 0); chk("R5 sref", int'(state), 4);
    for (int i = 0; i < 8; i++) step(0, i, 0);
    chk("R2 sref hold", int'(state), 4);
    step(1, 5, 0); chk("R3 bad exit err", int'(err), 1);
    step(0, 1, 0); step(0, 1, 0);
    step(1, 1, 0); chk("R3 exit", int'(state), 0);
    chk("R9 locked", int'(read_ok), 0);
    // R8 window: edges 1..SRX after exit
    for (int i = 1; i < SRX; i++) step(1, 1, 0);
    step(1, 3, 0); chk("R8 last window edge", int'(err), 1);
    step(1, 3, 0); chk("R8 after window", int'(state), 1);
    step(1, 4, 0);
    // R9 READ during lock
    step(1, 5, 0); chk("R9 early read", int'(err), 1);
    while (!read_ok) step(1, 1, 0);
    step(1, 5, 0); chk("R9 read ok", int'(err), 0);

    // second exit; AUTO REFRESH inside window
    step(1, 1, 0); step(0, 2, 0); step(0, 0, 0); step(1, 0, 0);
    step(1, 1, 0); step(0, 2, 0); chk("R8 aref in window", int'(err), 1);

    // biased random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic nk;
      r  = int'($urandom_range(0, 99));
      nk = (r < 70) ? cke : ~cke;
      r  = int'($urandom_range(0, 99));
      step(nk, (r < 55) ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)));
    end

    finish_run();
  end
endmodule